// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This peripheral keeps wall-clock time as an unsigned 32-bit count of seconds and is reached through an APB-style slave port that decodes a 4 KB window. A prescaler divides the system clock into a one-cycle enable pulse every `PRESCALE` cycles. Each pulse advances the count by one, and the count wraps modulo 2^32. Software sets the time by writing a target value to a load register. The counter cannot be stopped, so the control register always reads as enabled.

An alarm compares every newly advanced count with a match register for exact equality. A hit sets a sticky raw status flag. The level interrupt output is the raw flag ANDed with a one-bit mask. Any write to the clear register drops the flag. Eight identification bytes sit one per word at the top of the window.

Bus transfers are tracked by a phase machine with three states. `PH_IDLE` moves to `PH_SETUP` when select rises with enable low. `PH_SETUP` moves to `PH_ACCESS` when enable is seen, and that transition is the single cycle on which a write commits. It returns to `PH_IDLE` if select drops. `PH_ACCESS` goes back to `PH_SETUP` for a back-to-back transfer, and otherwise returns to `PH_IDLE`. Read data is combinational while select is high with write low, and it is zero at all other times.

Top module: `sec_rtc`

## Requirements
- R1: After reset the count, match, last-loaded value, mask and raw status all read 0, and `irq` is low.
- R2: The count (read at offset 0x00) advances by exactly one every `PRESCALE` clock cycles and holds its value between those advances.
- R3: A write to offset 0x08 makes the count equal the written value on the commit edge and restarts the prescaler, so the next advance comes `PRESCALE` cycles later. Reading 0x08 returns the last value written there.
- R4: Offset 0x04 holds the match value and reads back the last value written to it.
- R5: Raw status (offset 0x14, bit 0) sets when an advance produces a count equal to the match value. This includes a match below the current count, which is reached after the count wraps from 0xFFFFFFFF to 0.
- R6: The mask is bit 0 of offset 0x10 and reads back there. `irq` and the masked status (offset 0x18, bit 0) both equal raw AND mask, and a mask write changes `irq` from the cycle after its commit.
- R7: Any write to offset 0x1C clears raw status, whatever the written value.
- R8: When a clear write commits on the same edge as an advance that hits the match, raw status ends up set.
- R9: Offset 0x0C always reads 0x00000001, and writes to it have no effect.
- R10: Offsets 0xFE0 to 0xFFC read the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in rising address order, in bits 7:0 with the upper bits zero.
- R11: Reads of offset 0x1C and of unmapped offsets return 0 and change nothing. Writes to offsets 0x00, 0x0C, 0x14 and 0x18 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | System clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address within the window |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data |
| irq | output | 1 | Level interrupt, raw status AND mask |

## Verification
The hardest case to reach is R8: a clear write must commit on exactly the edge where the count steps onto the match value. The stimulus gets there by loading the count one below the match. A load restarts the prescaler, so the matching advance falls a known `PRESCALE` cycles after the load's commit edge. The bench then waits a counted number of cycles and starts a clear transfer whose commit edge lands on that advance. The wrap case of R5 is reached the same way, by loading 0xFFFFFFFF with a match of 1.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACCESS
    } apb_phase_e;

    localparam logic [7:0] OFS_COUNT  = 8'h00;
    localparam logic [7:0] OFS_MATCH  = 8'h04;
    localparam logic [7:0] OFS_LOAD   = 8'h08;
    localparam logic [7:0] OFS_CTRL   = 8'h0C;
    localparam logic [7:0] OFS_MASK   = 8'h10;
    localparam logic [7:0] OFS_RAW    = 8'h14;
    localparam logic [7:0] OFS_MASKED = 8'h18;
    localparam logic [7:0] OFS_CLEAR  = 8'h1C;

    function automatic logic [7:0] ident_byte(input logic [2:0] k);
        logic [7:0] b;
        unique case (k)
            3'd0: b = 8'h31;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtc_apb_phase.sv
module rtc_apb_phase
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb
);

    apb_phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (psel && !penable) state_d = PH_SETUP;
            PH_SETUP:  if (!psel) state_d = PH_IDLE;
                       else if (penable) state_d = PH_ACCESS;
            PH_ACCESS: state_d = (psel && !penable) ? PH_SETUP : PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        wr_stb = 1'b0;
        unique case (state_q)
            PH_SETUP:  wr_stb = psel && penable && pwrite;
            PH_IDLE,
            PH_ACCESS: wr_stb = 1'b0;
            default:   wr_stb = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned PRESCALE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int unsigned PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

    logic [PS_W-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           div_q <= '0;
        else if (restart || tick) div_q <= '0;
        else                  div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] load_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            load_q <= '0;
        end else if (load_en) begin
            cnt_q  <= load_val;
            load_q <= load_val;
        end else if (tick) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_en,
    input  logic [DATA_W-1:0] cnt,
    input  logic              match_wr,
    input  logic              mask_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] match_q,
    output logic              mask_q,
    output logic              raw_q,
    output logic              irq
);

    logic hit;

    assign hit = tick && !load_en && ((cnt + DATA_W'(1)) == match_q);
    assign irq = raw_q & mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
            mask_q  <= 1'b0;
            raw_q   <= 1'b0;
        end else begin
            if (match_wr) match_q <= wdata;
            if (mask_wr)  mask_q  <= wdata[0];
            if (hit)         raw_q <= 1'b1;
            else if (clr_wr) raw_q <= 1'b0;
        end
    end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned PRESCALE = 16
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq
);

    localparam int unsigned ID_TOP_W = ADDR_W - 5;

    logic              wr_stb, tick;
    logic [ADDR_W-1:0] addr_w;
    logic              unused_lo;
    logic              load_hit, match_hit, mask_hit, clr_hit, id_sel;
    logic [DATA_W-1:0] cnt_q, load_q, match_q;
    logic              mask_q, raw_q;
    logic [DATA_W-1:0] rd_mux;

    assign addr_w    = {paddr[ADDR_W-1:2], 2'b00};
    assign unused_lo = ^paddr[1:0];

    assign load_hit  = wr_stb && (addr_w == ADDR_W'(OFS_LOAD));
    assign match_hit = wr_stb && (addr_w == ADDR_W'(OFS_MATCH));
    assign mask_hit  = wr_stb && (addr_w == ADDR_W'(OFS_MASK));
    assign clr_hit   = wr_stb && (addr_w == ADDR_W'(OFS_CLEAR));
    assign id_sel    = (addr_w[ADDR_W-1:5] == {ID_TOP_W{1'b1}});

    rtc_apb_phase u_phase (
        .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .wr_stb(wr_stb)
    );

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk(pclk), .rst_n(presetn), .restart(load_hit), .tick(tick)
    );

    rtc_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(pclk), .rst_n(presetn), .tick(tick), .load_en(load_hit),
        .load_val(pwdata), .cnt_q(cnt_q), .load_q(load_q)
    );

    rtc_alarm #(.DATA_W(DATA_W)) u_alarm (
        .clk(pclk), .rst_n(presetn), .tick(tick), .load_en(load_hit),
        .cnt(cnt_q), .match_wr(match_hit), .mask_wr(mask_hit),
        .clr_wr(clr_hit), .wdata(pwdata), .match_q(match_q),
        .mask_q(mask_q), .raw_q(raw_q), .irq(irq)
    );

    always_comb begin
        rd_mux = '0;
        if (id_sel) begin
            rd_mux = DATA_W'(ident_byte(addr_w[4:2]));
        end else if (addr_w == ADDR_W'(OFS_COUNT)) begin
            rd_mux = cnt_q;
        end else if (addr_w == ADDR_W'(OFS_MATCH)) begin
            rd_mux = match_q;
        end else if (addr_w == ADDR_W'(OFS_LOAD)) begin
            rd_mux = load_q;
        end else if (addr_w == ADDR_W'(OFS_CTRL)) begin
            rd_mux = DATA_W'(1);
        end else if (addr_w == ADDR_W'(OFS_MASK)) begin
            rd_mux = DATA_W'(mask_q);
        end else if (addr_w == ADDR_W'(OFS_RAW)) begin
            rd_mux = DATA_W'(raw_q);
        end else if (addr_w == ADDR_W'(OFS_MASKED)) begin
            rd_mux = DATA_W'(raw_q & mask_q);
        end
    end

    assign prdata = (psel && !pwrite) ? rd_mux : '0;

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] prdata,
    input logic              irq,
    input logic              wr_stb,
    input logic              tick,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] match,
    input logic              raw
);

    logic [ADDR_W-1:0] a;
    logic ld, clr, mask_off, rd;

    assign a        = {paddr[ADDR_W-1:2], 2'b00};
    assign ld       = wr_stb && (a == ADDR_W'(8'h08));
    assign clr      = wr_stb && (a == ADDR_W'(8'h1C));
    assign mask_off = wr_stb && (a == ADDR_W'(8'h10)) && !pwdata[0];
    assign rd       = psel && !pwrite;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld) |=> (cnt == $past(cnt) + DATA_W'(1))); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(cnt)); // R2
    AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(pwdata))); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && ((cnt + DATA_W'(1)) == match)) |=> raw); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !tick) |=> !raw); // R7
    AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mask_off |=> !irq); // R6
    AST_CTRL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && a == ADDR_W'(8'h0C)) |-> (prdata == DATA_W'(1))); // R9
    AST_CLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && a == ADDR_W'(8'h1C)) |-> (prdata == '0)); // R11

endmodule

bind sec_rtc sec_rtc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(pclk), .rst_n(presetn), .psel(psel), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq),
    .wr_stb(wr_stb), .tick(tick), .cnt(cnt_q), .match(match_q), .raw(raw_q)
);

// File: tb/sec_rtc_test.sv
`timescale 1ns/1ps
module sec_rtc_test;

    localparam int unsigned AW = 12;
    localparam int unsigned DW = 32;
    localparam int unsigned PS = 16;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    exp_item_t sb[$];

    always #4 clk = ~clk;

    sec_rtc #(.ADDR_W(AW), .DATA_W(DW), .PRESCALE(PS)) uut (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq(irq)
    );

    // monitor: compares read data in each access phase with the queue head
    always begin
        @(negedge clk);
        #1;
        if (psel && penable && !pwrite) begin
            exp_item_t it;
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read: prdata=%h expected none", prdata);
            end else begin
                it = sb.pop_front();
                if (prdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s @%h: prdata=%h expected %h", it.tag, paddr, prdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        exp_item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        #1;
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s irq: actual=%b expected %b", tag, irq, e);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(12'h000, 32'h0, "R1 count");
        rd(12'h004, 32'h0, "R1 match");
        rd(12'h008, 32'h0, "R1 load");
        rd(12'h010, 32'h0, "R1 mask");
        rd(12'h014, 32'h0, "R1 raw");
        chk_irq(1'b0, "R1");

        // R9 control reads one, writes ignored
        rd(12'h00C, 32'h1, "R9 ctrl");
        wr(12'h00C, 32'h0);
        rd(12'h00C, 32'h1, "R9 ctrl after write");

        // R10 identification bytes
        for (int k = 0; k < 8; k++) begin
            logic [7:0] b;
            case (k)
                0: b = 8'h31; 1: b = 8'h10; 2: b = 8'h14; 3: b = 8'h00;
                4: b = 8'h0D; 5: b = 8'hF0; 6: b = 8'h05; default: b = 8'hB1;
            endcase
            rd(12'hFE0 + AW'(k * 4), {24'h0, b}, "R10 id");
        end

        // R11 unmapped and write-only reads
        rd(12'h020, 32'h0, "R11 unmapped");
        rd(12'h800, 32'h0, "R11 unmapped");
        rd(12'h01C, 32'h0, "R11 clear read");

        // R4 match readback, R3 load and prescaler restart, R2 stepping
        wr(12'h004, 32'h1234_5678);
        rd(12'h004, 32'h1234_5678, "R4 match");
        wr(12'h008, 32'h0000_1000);
        rd(12'h008, 32'h0000_1000, "R3 load readback");
        rd(12'h000, 32'h0000_1000, "R3 count loaded");
        repeat (12) @(negedge clk);
        rd(12'h000, 32'h0000_1001, "R3 first step");
        repeat (16) @(negedge clk);
        rd(12'h000, 32'h0000_1002, "R2 second step");

        // R11 writes to read-only registers ignored
        wr(12'h008, 32'h0000_0050);
        wr(12'h000, 32'h0000_9999);
        wr(12'h014, 32'h0000_0001);
        rd(12'h000, 32'h0000_0050, "R11 count write ignored");
        rd(12'h014, 32'h0, "R11 raw write ignored");

        // R5 alarm and R6 mask
        wr(12'h010, 32'h1);
        rd(12'h010, 32'h1, "R6 mask readback");
        wr(12'h004, 32'h0000_2002);
        wr(12'h008, 32'h0000_2000);
        rd(12'h014, 32'h0, "R5 raw before match");
        chk_irq(1'b0, "R5 before");
        repeat (36) @(negedge clk);
        rd(12'h014, 32'h1, "R5 raw on match");
        rd(12'h018, 32'h1, "R6 masked status");
        chk_irq(1'b1, "R6 enabled");
        wr(12'h010, 32'h0);
        chk_irq(1'b0, "R6 masked off");
        rd(12'h018, 32'h0, "R6 masked status off");
        rd(12'h01C, 32'h0, "R11 clear read");
        rd(12'h014, 32'h1, "R11 raw kept after clear read");
        wr(12'h010, 32'h1);
        chk_irq(1'b1, "R6 mask on");

        // R7 clear with value zero
        wr(12'h01C, 32'h0);
        rd(12'h014, 32'h0, "R7 clear zero value");
        chk_irq(1'b0, "R7");

        // R5 wraparound
        wr(12'h004, 32'h0000_0001);
        wr(12'h008, 32'hFFFF_FFFF);
        repeat (18) @(negedge clk);
        rd(12'h000, 32'h0, "R5 wrap to zero");
        rd(12'h014, 32'h0, "R5 no match yet");
        repeat (16) @(negedge clk);
        rd(12'h014, 32'h1, "R5 match after wrap");
        wr(12'h01C, 32'hFFFF_FFFE);
        rd(12'h014, 32'h0, "R7 clear bit0 zero");

        // R8 clear and match on the same edge
        wr(12'h004, 32'h0000_0301);
        wr(12'h008, 32'h0000_0300);
        repeat (14) @(negedge clk);
        wr(12'h01C, 32'h1);
        rd(12'h014, 32'h1, "R8 set wins");
        rd(12'h000, 32'h0000_0301, "R8 count stepped");
        wr(12'h01C, 32'h1);
        rd(12'h014, 32'h0, "R7 clear after set");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule